// File: doc/BRIEF.md
# Operand Address and Cycle-Penalty Generator

This block forms the 24-bit effective address of a data operand for a processor core whose accumulator and index registers can each be 8 or 16 bits wide. The core's decoder supplies an addressing-mode code, the operand bytes that follow the opcode, the direct-page base register, the data bank, both index registers, the index-width flag and the emulation flag. The block returns the effective address, the total instruction length in bytes so the program counter can advance, and the number of cycles the access costs beyond the base timing of the opcode.

The modes covered are immediate (8 and 16 bit), direct page, direct page indexed by either index register, absolute, absolute indexed for reads, absolute indexed by X for read-modify-write, long and long indexed. Penalty cycles depend on three things: whether the direct-page base is page aligned, how wide the index is, and whether indexing moves the address into another 256-byte page. Memory access, pointer fetch for indirect modes and opcode decode belong to other blocks.

Results are registered. A one-cycle start strobe captures the inputs, and on the next clock edge the outputs update together with a one-cycle valid pulse. The outputs keep their values until the next strobe.

Top module: `opaddr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `eff_addr`, `instr_len` and `extra_cyc` are all 0 until the first start strobe is taken.
- R2: A `start` sampled high at a clock edge produces `out_valid` high for exactly the next cycle, with all three results updated at that same edge. Without `start`, the results keep their values no matter how the inputs change.
- R3: Direct page (`mode`=2) gives address {8'h00, (dp_reg + opnd[7:0]) mod 2^16} and length 2. It costs 1 extra cycle when dp_reg[7:0] is nonzero and 0 otherwise.
- R4: Direct page indexed (`mode`=3 uses X, `mode`=4 uses Y) gives bank 0 and low 16 bits (dp_reg + opnd[7:0] + index) mod 2^16, with length 2. It costs 1 extra cycle, plus 1 more when dp_reg[7:0] is nonzero.
- R5: In direct page indexed with `emu`=1 and dp_reg[7:0]=0, address bits 15:8 equal dp_reg[15:8] and bits 7:0 equal (opnd[7:0] + index) mod 256. The access therefore wraps inside the direct page.
- R6: When `idx_narrow`=1 (8-bit index), only bits 7:0 of the index register are added in every indexed mode. Bits 15:8 of the register have no effect on the address.
- R7: Absolute (`mode`=5) gives {dbank, opnd[15:8], opnd[7:0]}, length 3 and 1 extra cycle.
- R8: Absolute indexed read (`mode`=6 uses X, `mode`=7 uses Y) gives ({dbank, opnd[15:0]} + index) mod 2^24, so a carry may enter the bank. Length is 3. It costs 1 extra cycle, plus 1 more when `idx_narrow`=0 or when address bits 15:8 differ from opnd[15:8].
- R9: Absolute X read-modify-write (`mode`=8) gives {dbank, (opnd[15:0] + X) mod 2^16}, so the bank never changes. Length is 3 and the cost is always 2 extra cycles.
- R10: Long (`mode`=9) gives opnd[23:0]. Long X (`mode`=10) gives (opnd[23:0] + X) mod 2^24. Both have length 4 and 2 extra cycles.
- R11: Immediate 8-bit (`mode`=0) gives length 2 and 0 extra cycles. Immediate 16-bit (`mode`=1) gives length 3 and 1 extra cycle. Both report address 0.
- R12: Mode codes 11 to 15 give address 0, length 1 and 0 extra cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and compute on this edge |
| mode | input | 4 | Addressing-mode code (see R3 to R12) |
| opnd | input | 24 | Operand bytes: first byte in 7:0, second in 15:8, third in 23:16 |
| dp_reg | input | 16 | Direct-page base register |
| dbank | input | 8 | Data bank |
| x_reg | input | 16 | X index register |
| y_reg | input | 16 | Y index register |
| idx_narrow | input | 1 | 1 = index registers are 8 bits wide |
| emu | input | 1 | Emulation mode flag |
| out_valid | output | 1 | One-cycle pulse after an accepted start |
| eff_addr | output | 24 | Effective address |
| instr_len | output | 3 | Instruction length in bytes |
| extra_cyc | output | 2 | Penalty cycles for this access |

## Verification
Every result passes through exactly one register, so an error in the address adders, the page-cross compare or the wrap select appears in the first valid cycle after the strobe that exposes it. The corner cases that reveal such errors are these:
- an 8-bit index whose high byte is nonzero;
- a page-aligned direct base in emulation mode;
- an absolute-indexed sum that carries into the bank;
- a read-modify-write sum that must not carry into the bank.

A capture register that fails to hold, or a stuck valid flag, shows up in the idle cycle right after the pulse, when the bench changes the inputs while `start` is low.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

   typedef enum logic [3:0] {
      AM_IMM8     = 4'd0,
      AM_IMM16    = 4'd1,
      AM_DP       = 4'd2,
      AM_DPX      = 4'd3,
      AM_DPY      = 4'd4,
      AM_ABS      = 4'd5,
      AM_ABSX     = 4'd6,
      AM_ABSY     = 4'd7,
      AM_ABSX_RMW = 4'd8,
      AM_LONG     = 4'd9,
      AM_LONGX    = 4'd10
   } amode_e;

   localparam int MODE_W = 4;

endpackage

// File: rtl/opaddr_index_sel.sv
// Presents an index register at its active width: with a narrow index,
// only the low byte takes part in address arithmetic.
module opaddr_index_sel #(
   parameter int BYTE_W = 8,
   parameter bit NARROW_SUPPORT = 1'b1
) (
   input  logic [2*BYTE_W-1:0] raw,
   input  logic                narrow,
   output logic [2*BYTE_W-1:0] eff
);
   localparam int WORD_W = 2 * BYTE_W;

   generate
      if (NARROW_SUPPORT) begin : g_narrow
         assign eff = narrow ? {{BYTE_W{1'b0}}, raw[BYTE_W-1:0]} : raw;
      end else begin : g_wide_only
         logic unused_narrow;
         assign unused_narrow = narrow;
         assign eff = raw[WORD_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/opaddr_dp_unit.sv
// Direct-page address: base plus byte offset plus optional index, in bank 0.
// An emulation-mode access through a page-aligned base wraps inside that page.
module opaddr_dp_unit #(
   parameter int BYTE_W = 8
) (
   input  logic [2*BYTE_W-1:0] dp_base,
   input  logic [BYTE_W-1:0]   offset,
   input  logic [2*BYTE_W-1:0] index,
   input  logic                use_index,
   input  logic                emu,
   output logic [2*BYTE_W-1:0] addr16,
   output logic                misaligned
);
   localparam int WORD_W = 2 * BYTE_W;

   logic [WORD_W-1:0] addend;
   logic [WORD_W-1:0] sum;
   logic              low_zero;
   logic              page_wrap;

   assign addend     = use_index ? index : '0;
   assign sum        = dp_base + {{BYTE_W{1'b0}}, offset} + addend;
   assign low_zero   = (dp_base[BYTE_W-1:0] == '0);
   assign misaligned = !low_zero;
   assign page_wrap  = use_index && emu && low_zero;
   assign addr16     = page_wrap ? {dp_base[WORD_W-1:BYTE_W], sum[BYTE_W-1:0]} : sum;
endmodule

// File: rtl/opaddr_abs_unit.sv
// Absolute and long address formation with optional indexing. A read sum
// may carry into the bank byte; a read-modify-write sum stays in its bank.
module opaddr_abs_unit #(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0]   bank,
   input  logic [2*BYTE_W-1:0] op_word,
   input  logic [BYTE_W-1:0]   op_bank,
   input  logic [2*BYTE_W-1:0] index,
   input  logic                long_sel,
   input  logic                index_en,
   input  logic                bank_lock,
   output logic [3*BYTE_W-1:0] addr,
   output logic                page_cross
);
   localparam int WORD_W = 2 * BYTE_W;
   localparam int ADDR_W = 3 * BYTE_W;

   logic [WORD_W-1:0] addend;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] full_sum;
   logic [WORD_W-1:0] word_sum;

   assign addend     = index_en ? index : '0;
   assign base       = {(long_sel ? op_bank : bank), op_word};
   assign full_sum   = base + {{BYTE_W{1'b0}}, addend};
   assign word_sum   = op_word + addend;
   assign addr       = bank_lock ? {bank, word_sum} : full_sum;
   assign page_cross = (base[WORD_W-1:BYTE_W] != full_sum[WORD_W-1:BYTE_W]);
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
   import opaddr_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int LEN_W   = 3,
   parameter int EXTRA_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [MODE_W-1:0]     mode,
   input  logic [3*BYTE_W-1:0]   opnd,
   input  logic [2*BYTE_W-1:0]   dp_reg,
   input  logic [BYTE_W-1:0]     dbank,
   input  logic [2*BYTE_W-1:0]   x_reg,
   input  logic [2*BYTE_W-1:0]   y_reg,
   input  logic                  idx_narrow,
   input  logic                  emu,
   output logic                  out_valid,
   output logic [3*BYTE_W-1:0]   eff_addr,
   output logic [LEN_W-1:0]      instr_len,
   output logic [EXTRA_W-1:0]    extra_cyc
);
   localparam int WORD_W  = 2 * BYTE_W;
   localparam int ADDR_W  = 3 * BYTE_W;
   localparam int N_INDEX = 2;

   // elaboration-time parameter checks
   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("opaddr_gen: BYTE_W must be at least 2");
      end
      if (LEN_W < 3) begin : g_bad_len
         $error("opaddr_gen: LEN_W must hold the value 4");
      end
      if (EXTRA_W < 2) begin : g_bad_extra
         $error("opaddr_gen: EXTRA_W must hold the value 2");
      end
   endgenerate

   amode_e am;
   assign am = amode_e'(mode);

   // index registers at active width
   logic [WORD_W-1:0] idx_raw [N_INDEX];
   logic [WORD_W-1:0] idx_eff [N_INDEX];
   assign idx_raw[0] = x_reg;
   assign idx_raw[1] = y_reg;

   generate
      for (genvar gi = 0; gi < N_INDEX; gi++) begin : g_idx
         opaddr_index_sel #(.BYTE_W(BYTE_W), .NARROW_SUPPORT(1'b1)) u_sel (
            .raw    (idx_raw[gi]),
            .narrow (idx_narrow),
            .eff    (idx_eff[gi])
         );
      end
   endgenerate

   logic              use_y;
   logic [WORD_W-1:0] idx_pick;
   assign use_y    = (am == AM_DPY) || (am == AM_ABSY);
   assign idx_pick = use_y ? idx_eff[1] : idx_eff[0];

   // direct page path
   logic              dp_indexed;
   logic [WORD_W-1:0] dp_addr;
   logic              dp_misaligned;
   assign dp_indexed = (am == AM_DPX) || (am == AM_DPY);

   opaddr_dp_unit #(.BYTE_W(BYTE_W)) u_dp (
      .dp_base    (dp_reg),
      .offset     (opnd[BYTE_W-1:0]),
      .index      (idx_pick),
      .use_index  (dp_indexed),
      .emu        (emu),
      .addr16     (dp_addr),
      .misaligned (dp_misaligned)
   );

   // absolute and long path
   logic              abs_long;
   logic              abs_indexed;
   logic              abs_lock;
   logic [ADDR_W-1:0] abs_addr;
   logic              abs_cross;
   assign abs_long    = (am == AM_LONG) || (am == AM_LONGX);
   assign abs_indexed = (am == AM_ABSX) || (am == AM_ABSY) ||
                        (am == AM_ABSX_RMW) || (am == AM_LONGX);
   assign abs_lock    = (am == AM_ABSX_RMW);

   opaddr_abs_unit #(.BYTE_W(BYTE_W)) u_abs (
      .bank       (dbank),
      .op_word    (opnd[WORD_W-1:0]),
      .op_bank    (opnd[ADDR_W-1:WORD_W]),
      .index      (idx_pick),
      .long_sel   (abs_long),
      .index_en   (abs_indexed),
      .bank_lock  (abs_lock),
      .addr       (abs_addr),
      .page_cross (abs_cross)
   );

   // result selection
   logic [ADDR_W-1:0]  addr_n;
   logic [LEN_W-1:0]   len_n;
   logic [EXTRA_W-1:0] extra_n;
   logic [EXTRA_W-1:0] align_pen;
   logic [EXTRA_W-1:0] cross_pen;

   assign align_pen = {{(EXTRA_W-1){1'b0}}, dp_misaligned};
   assign cross_pen = {{(EXTRA_W-1){1'b0}}, (!idx_narrow || abs_cross)};

   always_comb begin
      addr_n  = '0;
      len_n   = LEN_W'(1);
      extra_n = '0;
      case (am)
         AM_IMM8: begin
            len_n   = LEN_W'(2);
         end
         AM_IMM16: begin
            len_n   = LEN_W'(3);
            extra_n = EXTRA_W'(1);
         end
         AM_DP: begin
            addr_n  = {{BYTE_W{1'b0}}, dp_addr};
            len_n   = LEN_W'(2);
            extra_n = align_pen;
         end
         AM_DPX, AM_DPY: begin
            addr_n  = {{BYTE_W{1'b0}}, dp_addr};
            len_n   = LEN_W'(2);
            extra_n = EXTRA_W'(1) + align_pen;
         end
         AM_ABS: begin
            addr_n  = abs_addr;
            len_n   = LEN_W'(3);
            extra_n = EXTRA_W'(1);
         end
         AM_ABSX, AM_ABSY: begin
            addr_n  = abs_addr;
            len_n   = LEN_W'(3);
            extra_n = EXTRA_W'(1) + cross_pen;
         end
         AM_ABSX_RMW: begin
            addr_n  = abs_addr;
            len_n   = LEN_W'(3);
            extra_n = EXTRA_W'(2);
         end
         AM_LONG, AM_LONGX: begin
            addr_n  = abs_addr;
            len_n   = LEN_W'(4);
            extra_n = EXTRA_W'(2);
         end
         default: begin
            addr_n  = '0;
            len_n   = LEN_W'(1);
            extra_n = '0;
         end
      endcase
   end

   // output registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         eff_addr  <= '0;
         instr_len <= '0;
         extra_cyc <= '0;
      end else begin
         out_valid <= start;
         if (start) begin
            eff_addr  <= addr_n;
            instr_len <= len_n;
            extra_cyc <= extra_n;
         end
      end
   end
endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk
   import opaddr_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int LEN_W   = 3,
   parameter int EXTRA_W = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic [MODE_W-1:0]   mode,
   input logic [BYTE_W-1:0]   dbank,
   input logic                out_valid,
   input logic [3*BYTE_W-1:0] eff_addr,
   input logic [LEN_W-1:0]    instr_len,
   input logic [EXTRA_W-1:0]  extra_cyc
);
   localparam int ADDR_W = 3 * BYTE_W;
   localparam int WORD_W = 2 * BYTE_W;

   // R2
   valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> out_valid);

   // R2
   valid_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !out_valid);

   // R2
   results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(eff_addr) && $stable(instr_len) && $stable(extra_cyc)));

   // R3
   dp_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (mode == AM_DP || mode == AM_DPX || mode == AM_DPY))
      |=> (eff_addr[ADDR_W-1:WORD_W] == '0 && instr_len == LEN_W'(2)));

   // R9
   rmw_bank_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode == AM_ABSX_RMW)
      |=> (eff_addr[ADDR_W-1:WORD_W] == $past(dbank) && extra_cyc == EXTRA_W'(2)));

   // R10
   long_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (mode == AM_LONG || mode == AM_LONGX))
      |=> (instr_len == LEN_W'(4) && extra_cyc == EXTRA_W'(2)));

   // R11
   imm_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (mode == AM_IMM8 || mode == AM_IMM16)) |=> (eff_addr == '0));

   // R4
   penalty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      extra_cyc <= EXTRA_W'(2));
endmodule

bind opaddr_gen opaddr_gen_chk #(
   .BYTE_W (BYTE_W),
   .LEN_W  (LEN_W),
   .EXTRA_W(EXTRA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mode      (mode),
   .dbank     (dbank),
   .out_valid (out_valid),
   .eff_addr  (eff_addr),
   .instr_len (instr_len),
   .extra_cyc (extra_cyc)
);

// File: tb/tb_opaddr_gen.sv
`timescale 1ns/1ps
module tb_opaddr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic [23:0] opnd = '0;
   logic [15:0] dp_reg = '0;
   logic [7:0]  dbank = '0;
   logic [15:0] x_reg = '0;
   logic [15:0] y_reg = '0;
   logic        idx_narrow = 1'b0;
   logic        emu = 1'b0;
   logic        out_valid;
   logic [23:0] eff_addr;
   logic [2:0]  instr_len;
   logic [1:0]  extra_cyc;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   opaddr_gen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opnd(opnd),
      .dp_reg(dp_reg), .dbank(dbank), .x_reg(x_reg), .y_reg(y_reg),
      .idx_narrow(idx_narrow), .emu(emu), .out_valid(out_valid),
      .eff_addr(eff_addr), .instr_len(instr_len), .extra_cyc(extra_cyc)
   );

   // behavioural reference state
   int  m_addr = 0, m_len = 0, m_extra = 0, m_mode = -1;
   bit  m_valid = 0;

   function automatic string tag_of(int md);
      case (md)
         -1:       return "R1";
         0, 1:     return "R11";
         2:        return "R3";
         3, 4:     return "R4";
         5:        return "R7";
         6, 7:     return "R8";
         8:        return "R9";
         9, 10:    return "R10";
         default:  return "R12";
      endcase
   endfunction

   task automatic reference(output int a, output int l, output int e);
      int idx, d, o0, o16, o24, base, s;
      bit useY;
      useY = (mode == 4) || (mode == 7);
      idx  = useY ? int'(y_reg) : int'(x_reg);
      if (idx_narrow) idx = idx % 256;            // R6
      d    = int'(dp_reg);
      o0   = int'(opnd[7:0]);
      o16  = int'(opnd[15:0]);
      o24  = int'(opnd);
      a = 0; l = 1; e = 0;
      case (int'(mode))
         0: begin l = 2; e = 0; end
         1: begin l = 3; e = 1; end
         2: begin a = (d + o0) % 65536; l = 2; e = (d % 256 != 0) ? 1 : 0; end
         3, 4: begin
            s = (d + o0 + idx) % 65536;
            if (emu && (d % 256 == 0)) s = (d / 256) * 256 + (o0 + idx) % 256;  // R5
            a = s; l = 2; e = 1 + ((d % 256 != 0) ? 1 : 0);
         end
         5: begin a = int'(dbank) * 65536 + o16; l = 3; e = 1; end
         6, 7: begin
            base = int'(dbank) * 65536 + o16;
            a = (base + idx) % 16777216;
            l = 3;
            e = 1 + ((!idx_narrow || ((base / 256) % 256 != (a / 256) % 256)) ? 1 : 0);
         end
         8: begin a = int'(dbank) * 65536 + (o16 + int'(x_reg) % (idx_narrow ? 256 : 65536)) % 65536;
                  l = 3; e = 2; end
         9: begin a = o24; l = 4; e = 2; end
         10: begin a = (o24 + idx) % 16777216; l = 4; e = 2; end
         default: begin a = 0; l = 1; e = 0; end
      endcase
   endtask

   always @(posedge clk) begin
      int a, l, e;
      cycles++;
      if (!rst_n) begin
         m_addr = 0; m_len = 0; m_extra = 0; m_valid = 0; m_mode = -1;
      end else begin
         m_valid = start;
         if (start) begin
            reference(a, l, e);
            m_addr = a; m_len = l; m_extra = e; m_mode = int'(mode);
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("R2", "out_valid", int'(out_valid), int'(m_valid));
         check(tag_of(m_mode), "eff_addr", int'(eff_addr), m_addr);
         check(tag_of(m_mode), "instr_len", int'(instr_len), m_len);
         check(tag_of(m_mode), "extra_cyc", int'(extra_cyc), m_extra);
      end
   end

   task automatic issue(input int md, input int op, input int d, input int b,
                        input int x, input int y, input bit nar, input bit em);
      @(negedge clk);
      mode = 4'(md); opnd = 24'(op); dp_reg = 16'(d); dbank = 8'(b);
      x_reg = 16'(x); y_reg = 16'(y); idx_narrow = nar; emu = em;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic idle_scramble();
      // R2: inputs change without start; results must hold
      @(negedge clk);
      mode = 4'($urandom); opnd = 24'($urandom); x_reg = 16'($urandom);
      dbank = 8'($urandom); dp_reg = 16'($urandom);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1", "reset out_valid", int'(out_valid), 0);
      check("R1", "reset eff_addr", int'(eff_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "post-reset instr_len", int'(instr_len), 0);
      check("R1", "post-reset extra_cyc", int'(extra_cyc), 0);

      // R11 immediates
      issue(0, 'h123456, 0, 0, 0, 0, 0, 0);
      issue(1, 'h123456, 0, 0, 0, 0, 0, 0);
      // R3 aligned and misaligned direct page, sum wrap at 16 bits
      issue(2, 'h0000F0, 'h1200, 0, 0, 0, 0, 0);
      issue(2, 'h0000F0, 'hFF40, 0, 0, 0, 0, 0);
      // R4 / R5 direct page indexed
      issue(3, 'h0000F0, 'h1234, 0, 'h0020, 0, 1, 0);
      issue(4, 'h0000F0, 'h3400, 0, 0, 'h0030, 1, 1);   // R5 wrap in page
      issue(3, 'h0000F0, 'h3400, 0, 'h0030, 0, 1, 0);   // no emu: carries
      issue(3, 'h0000F0, 'h3401, 0, 'h0030, 0, 1, 1);   // emu, misaligned
      // R6 narrow index ignores high byte
      issue(3, 'h000010, 'h2000, 0, 'hAB05, 0, 1, 0);
      issue(6, 'h001000, 0, 'h05, 'h7F20, 0, 1, 0);
      // R7 absolute
      issue(5, 'hEE3412, 0, 'h7E, 0, 0, 0, 0);
      // R8 page cross and no cross, wide index, bank carry
      issue(6, 'h0010F0, 0, 'h01, 'h0020, 0, 1, 0);
      issue(7, 'h001010, 0, 'h01, 0, 'h0020, 1, 0);
      issue(7, 'h001010, 0, 'h01, 0, 'h0020, 0, 0);
      issue(6, 'h00FFF0, 0, 'h02, 'h0020, 0, 1, 0);
      // R9 read-modify-write stays in bank
      issue(8, 'h00FFF0, 0, 'h02, 'h0020, 0, 0, 0);
      // R10 long and long indexed wrap
      issue(9, 'hABCDEF, 0, 0, 0, 0, 0, 0);
      issue(10, 'hFFFFF0, 0, 0, 'h0100, 0, 0, 0);
      // R12 unused codes
      issue(11, 'h123456, 'h1111, 'h22, 'h33, 'h44, 0, 0);
      issue(15, 'h123456, 'h1111, 'h22, 'h33, 'h44, 0, 1);
      idle_scramble();
      idle_scramble();

      for (int i = 0; i < 400; i++) begin
         issue(int'($urandom % 16), int'($urandom % 16777216), int'($urandom % 65536),
               int'($urandom % 256), int'($urandom % 65536), int'($urandom % 65536),
               bit'($urandom % 2), bit'($urandom % 2));
         if (i % 7 == 0) idle_scramble();
      end
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles > 50000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<50000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule